// File: doc/BRIEF.md
# Debounced Event Timestamp Capture

This block sits beside a real-time-clock core and watches a single external event pin. It brings the pin into the clock domain and qualifies it against a chosen active level. An optional chatter filter requires that level to persist for a programmable number of 16.384 kHz ticks. When an event qualifies, the block can latch the live seconds and hundredths-of-second values, both in BCD, into two read-only capture registers.

For precise time setting, software can arm a one-shot alignment. Time keeps running until the next qualified event. On that event the block pulses an output that tells the clock core to zero its sub-second divider and hundredths counter, and the arm flag then drops by itself. Arming also wipes both capture registers. Writing the flag back to zero before an event cancels the pending alignment.

The register port has three live addresses: 0x0 returns the captured hundredths, 0x1 returns the captured seconds and 0xF holds the event control fields.

Top module: `evt_stamp_top`

## Requirements
- R1: After reset, addresses 0x0, 0x1 and 0xF all read 0x00 and `subSecClear` is low.
- R2: When an event qualifies while control bit 0 (capture enable) is 1, address 0x0 then reads the `liveHund` value and address 0x1 reads `{1'b0, liveSec}`. Both are the values present on the clock edge after the event.
- R3: When an event qualifies while control bit 0 is 0, both capture registers keep their values.
- R4: Control bit 1 selects the active level of `evtPin`: 1 means high and 0 means low.
- R5: Control bits 3:2 select the filter. Code 0 means none, and the event pulse appears on the 3rd clock edge after the pin reaches the active level. Codes 1, 2 and 3 require L = SHORT_TICKS, MID_TICKS or LONG_TICKS ticks of continuous active level. With `tick` high on every cycle, the event appears on clock edge 2+L. While `tick` stays low, no filtered event occurs.
- R6: An active-level pulse shorter than the filter period produces no event.
- R7: A continuously held active level produces exactly one event. A further event needs the pin to return to the inactive level first.
- R8: Control bit 4 (arm) set at the time of an event causes a one-cycle high pulse on `subSecClear`, and bit 4 then reads 0.
- R9: Writing 0xF with bit 4 set clears both capture registers to 0x00.
- R10: Writing 0xF with bit 4 clear before the event cancels the alignment, so no `subSecClear` pulse follows.
- R11: Writes to 0x0 and 0x1 have no effect. Other unmapped addresses read 0x00. Address 0xF reads back bits 4:0 as written, with bits 7:5 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 16.384 kHz timing strobe |
| evtPin | input | 1 | Asynchronous external event pin |
| liveHund | input | 8 | Live hundredths of a second, two BCD digits |
| liveSec | input | 7 | Live seconds, BCD |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for `addr` (combinational) |
| subSecClear | output | 1 | One-cycle pulse that clears the clock core's sub-second counters |

## Verification
The case that is hardest to reach from the ports is the exact edge on which a filtered event qualifies. That edge sits behind two synchronizer stages and a tick counter, and the whole path has to be lined up against the edge on which the capture registers load. The bench sweeps both levels, all four filter codes and both capture-enable settings on a build with short filter periods. It measures the latency of the alignment pulse and compares it with 3 or 2+L cycles. It then changes the live time while the pin is still held, which shows that no second capture occurs. Separate runs cover chatter shorter than the period, a stopped tick and a cancelled arm.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

  localparam logic [3:0] ADDR_HUND = 4'h0;
  localparam logic [3:0] ADDR_SEC  = 4'h1;
  localparam logic [3:0] ADDR_CTRL = 4'hF;

  // control word layout, bit 4 down to bit 0
  typedef struct packed {
    logic       armed;
    logic [1:0] debSel;
    logic       levelHigh;
    logic       capEn;
  } ctrlReg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clearCaps;
  } dpStrobe_t;

endpackage

// File: rtl/evt_stamp_filter.sv
module evt_stamp_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_TICKS = 64,
  parameter int MID_TICKS   = 256,
  parameter int LONG_TICKS  = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       pinAsync,
  input  logic       levelHigh,
  input  logic [1:0] debSel,
  output logic       evtPulse
);
  localparam int CNT_W = $clog2(LONG_TICKS + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinSync;
  logic                   active;
  logic                   fired;
  logic                   reached;
  logic [CNT_W-1:0]       tickCnt;
  logic [CNT_W-1:0]       limit;

  assign pinSync = syncQ[SYNC_STAGES-1];
  assign active  = (pinSync == levelHigh);

  always_comb begin
    case (debSel)
      2'd1:    limit = CNT_W'(SHORT_TICKS);
      2'd2:    limit = CNT_W'(MID_TICKS);
      2'd3:    limit = CNT_W'(LONG_TICKS);
      default: limit = '0;
    endcase
  end

  assign reached = (debSel == 2'd0) || (tick && (tickCnt == limit - 1'b1));

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinAsync};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinAsync;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      fired    <= 1'b0;
      evtPulse <= 1'b0;
    end else begin
      evtPulse <= 1'b0;
      if (!active) begin
        tickCnt <= '0;
        fired   <= 1'b0;
      end else if (!fired) begin
        if (reached) begin
          evtPulse <= 1'b1;
          fired    <= 1'b1;
          tickCnt  <= '0;
        end else if (tick) begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evt_stamp_ctrl.sv
module evt_stamp_ctrl
  import evt_stamp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic [3:0] addr,
  input  logic [7:0] wrData,
  input  logic      evtPulse,
  output ctrlReg_t  ctrlQ,
  output dpStrobe_t strobe,
  output logic      subSecClear
);
  logic ctrlWrite;

  assign ctrlWrite = wrEn && (addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWrite) begin
      ctrlQ <= ctrlReg_t'(wrData[4:0]);
    end else if (evtPulse && ctrlQ.armed) begin
      ctrlQ.armed <= 1'b0;
    end
  end

  always_comb begin
    strobe.capture   = evtPulse && ctrlQ.capEn;
    strobe.clearCaps = ctrlWrite && wrData[4];
  end

  assign subSecClear = evtPulse && ctrlQ.armed;
endmodule

// File: rtl/evt_stamp_dp.sv
module evt_stamp_dp
  import evt_stamp_pkg::*;
#(
  parameter int HUND_W = 8,
  parameter int SEC_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [HUND_W-1:0] liveHund,
  input  logic [SEC_W-1:0]  liveSec,
  input  logic [3:0]        addr,
  input  ctrlReg_t          ctrlQ,
  output logic [HUND_W-1:0] capHund,
  output logic [SEC_W-1:0]  capSec,
  output logic [DATA_W-1:0] rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capHund <= '0;
      capSec  <= '0;
    end else if (strobe.clearCaps) begin
      capHund <= '0;
      capSec  <= '0;
    end else if (strobe.capture) begin
      capHund <= liveHund;
      capSec  <= liveSec;
    end
  end

  always_comb begin
    case (addr)
      ADDR_HUND: rdData = DATA_W'(capHund);
      ADDR_SEC:  rdData = DATA_W'(capSec);
      ADDR_CTRL: rdData = DATA_W'(ctrlQ);
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/evt_stamp_top.sv
module evt_stamp_top
  import evt_stamp_pkg::*;
#(
  parameter int SHORT_TICKS = 64,
  parameter int MID_TICKS   = 256,
  parameter int LONG_TICKS  = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       evtPin,
  input  logic [7:0] liveHund,
  input  logic [6:0] liveSec,
  input  logic       wrEn,
  input  logic [3:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       subSecClear
);
  ctrlReg_t  ctrlQ;
  dpStrobe_t strobe;
  logic      evtPulse;
  logic [7:0] capHund;
  logic [6:0] capSec;

  evt_stamp_filter #(
    .SYNC_STAGES(2),
    .SHORT_TICKS(SHORT_TICKS),
    .MID_TICKS  (MID_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) i_filter (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .pinAsync (evtPin),
    .levelHigh(ctrlQ.levelHigh),
    .debSel   (ctrlQ.debSel),
    .evtPulse (evtPulse)
  );

  evt_stamp_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .evtPulse   (evtPulse),
    .ctrlQ      (ctrlQ),
    .strobe     (strobe),
    .subSecClear(subSecClear)
  );

  evt_stamp_dp #(.HUND_W(8), .SEC_W(7), .DATA_W(8)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .liveHund(liveHund),
    .liveSec (liveSec),
    .addr    (addr),
    .ctrlQ   (ctrlQ),
    .capHund (capHund),
    .capSec  (capSec),
    .rdData  (rdData)
  );
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk
  import evt_stamp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [3:0] addr,
  input logic [7:0] wrData,
  input logic [7:0] liveHund,
  input logic [6:0] liveSec,
  input logic       evtPulse,
  input ctrlReg_t   ctrlQ,
  input logic [7:0] capHund,
  input logic [6:0] capSec,
  input logic       subSecClear
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (addr == ADDR_CTRL);

  a_r2_capture_live: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse && ctrlQ.capEn && !ctrlWr) |=> (capHund == $past(liveHund)) && (capSec == $past(liveSec)));

  a_r3_no_capture: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ.capEn && !ctrlWr) |=> $stable(capHund) && $stable(capSec));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> !evtPulse);

  a_r8_clear_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    subSecClear |=> !subSecClear);

  a_r8_arm_drops: assert property (@(posedge clk) disable iff (!rstN)
    (subSecClear && !ctrlWr) |=> !ctrlQ.armed);

  a_r9_arm_wipes: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[4]) |=> (capHund == 8'h00) && (capSec == 7'h00));

  a_r11_read_only: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr != ADDR_CTRL) && !evtPulse) |=> $stable(capHund) && $stable(capSec));
endmodule

bind evt_stamp_top evt_stamp_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .liveHund   (liveHund),
  .liveSec    (liveSec),
  .evtPulse   (evtPulse),
  .ctrlQ      (ctrlQ),
  .capHund    (capHund),
  .capSec     (capSec),
  .subSecClear(subSecClear)
);

// File: tb/test_evt_stamp_top.sv
module test_evt_stamp_top;
  localparam int SHORT_T = 3;
  localparam int MID_T   = 5;
  localparam int LONG_T  = 9;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       evtPin = 1'b0;
  logic [7:0] liveHund = 8'h00;
  logic [6:0] liveSec = 7'h00;
  logic       wrEn = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       subSecClear;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  evt_stamp_top #(.SHORT_TICKS(SHORT_T), .MID_TICKS(MID_T), .LONG_TICKS(LONG_T)) i_evt_stamp_top (
    .clk(clk), .rstN(rstN), .tick(tick), .evtPin(evtPin),
    .liveHund(liveHund), .liveSec(liveSec), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .subSecClear(subSecClear)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // count clearing pulses seen over n cycles
  task automatic watchClear(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (subSecClear) pulses++;
    end
  endtask

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int periodOf(input int ds);
    case (ds)
      1: return SHORT_T;
      2: return MID_T;
      3: return LONG_T;
      default: return 0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] rd;
    int lat, pulses, k;
    logic [7:0] expH;
    logic [6:0] expS;
    k = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(4'h0, rd); check("R1 hund", rd, 8'h00);
    rdReg(4'h1, rd); check("R1 sec",  rd, 8'h00);
    rdReg(4'hF, rd); check("R1 ctrl", rd, 8'h00);
    check("R1 subSecClear", subSecClear, 0);

    // sweep: level x filter code x capture enable
    for (int lvl = 0; lvl < 2; lvl++) begin
      for (int ds = 0; ds < 4; ds++) begin
        for (int cap = 0; cap < 2; cap++) begin
          k++;
          evtPin = ~lvl[0];
          idle(4);
          wrReg(4'hF, {3'b000, 1'b1, ds[1:0], lvl[0], cap[0]});
          rdReg(4'h0, rd); check("R9 hund wiped", rd, 8'h00);
          rdReg(4'h1, rd); check("R9 sec wiped",  rd, 8'h00);
          liveHund = toBcd((k * 7) % 100);
          liveSec  = 7'(toBcd((k * 13) % 60));
          expH = cap ? liveHund : 8'h00;
          expS = cap ? liveSec  : 7'h00;
          evtPin = lvl[0];
          lat = 0;
          for (int n = 1; n <= 40; n++) begin
            @(posedge clk); @(negedge clk);
            if (subSecClear) begin lat = n; break; end
          end
          // R4 R5 R8 latency of aligned clear against level and filter code
          check("R5 latency", lat, (ds == 0) ? 3 : 2 + periodOf(ds));
          idle(1);
          check("R8 pulse one cycle", subSecClear, 0);
          rdReg(4'hF, rd); check("R8 arm dropped", rd, {3'b000, 1'b0, ds[1:0], lvl[0], cap[0]});
          rdReg(4'h0, rd); check("R2 R3 hund", rd, expH);
          rdReg(4'h1, rd); check("R2 R3 sec",  rd, {1'b0, expS});
          // R7 hold: no second event
          wrReg(4'hF, {3'b000, 1'b0, ds[1:0], lvl[0], 1'b1});
          liveHund = 8'h99; liveSec = 7'h59;
          idle(LONG_T + 6);
          rdReg(4'h0, rd); check("R7 no recapture", rd, expH);
          evtPin = ~lvl[0];
          idle(4);
        end
      end
    end

    // R7 re-event after release
    evtPin = 1'b0; idle(4);
    wrReg(4'hF, 8'h03);            // high level, capture, no filter
    liveHund = 8'h42; liveSec = 7'h17;
    evtPin = 1'b1; idle(6);
    evtPin = 1'b0; idle(4);
    liveHund = 8'h77;
    evtPin = 1'b1; idle(6);
    rdReg(4'h0, rd); check("R7 second event after release", rd, 8'h77);
    evtPin = 1'b0; idle(4);

    // R6 chatter shorter than the longest period
    wrReg(4'hF, 8'h1F);            // arm, code 3, high, capture
    liveHund = 8'h31; liveSec = 7'h22;
    evtPin = 1'b1; idle(LONG_T - 3);
    evtPin = 1'b0;
    watchClear(LONG_T + 6, pulses);
    check("R6 no clear on chatter", pulses, 0);
    rdReg(4'h0, rd); check("R6 no capture", rd, 8'h00);
    rdReg(4'hF, rd); check("R6 still armed", rd, 8'h1F);

    // R5 tick halted blocks filtered events
    tick = 1'b0;
    evtPin = 1'b1;
    watchClear(LONG_T + 10, pulses);
    check("R5 no event without ticks", pulses, 0);
    tick = 1'b1;
    watchClear(LONG_T + 4, pulses);
    check("R5 event once ticks resume", pulses, 1);
    evtPin = 1'b0; idle(4);

    // R10 cancel
    wrReg(4'hF, 8'h13);            // arm, no filter, high, capture
    wrReg(4'hF, 8'h03);            // cancel
    liveHund = 8'h58; liveSec = 7'h41;
    evtPin = 1'b1;
    watchClear(10, pulses);
    check("R10 cancelled clear", pulses, 0);
    rdReg(4'h0, rd); check("R10 capture still works", rd, 8'h58);
    evtPin = 1'b0; idle(4);

    // R11 read-only capture addresses and unmapped reads
    wrReg(4'h0, 8'h55);
    wrReg(4'h1, 8'h33);
    rdReg(4'h0, rd); check("R11 hund read-only", rd, 8'h58);
    rdReg(4'h1, rd); check("R11 sec read-only",  rd, 8'h41);
    rdReg(4'h5, rd); check("R11 unmapped", rd, 8'h00);
    wrReg(4'hF, 8'hEC);
    rdReg(4'hF, rd); check("R11 ctrl upper bits", rd, 8'h0C);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule